// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter with Snapshot Reads and Staged Writes

This block keeps wall-clock time and date as binary-coded-decimal counters: seconds, minutes, hours, weekday, day of month, month and a two-digit year. Each pulse on the `tick` input is one second. The counters handle carries from seconds up to years. They apply the correct month lengths and add 29 February in leap years. The hour field can be in 24-hour form or in 12-hour form with an afternoon flag.

A serial-bus slave front end, outside this block, drives the register port through strobes:

- On the acknowledge edge before read data, it pulses `ack_rd`. All following reads come from a frozen copy of the time.
- On the acknowledge edge before write data, it pulses `ack_wr`. Write bytes then go into a staging buffer.
- At a valid stop condition, it pulses `stop_ok`. Only the bytes written in the transaction are moved into the live counters.
- On a failed or aborted transaction, it pulses `abort`. The staged bytes are thrown away.

After reset, which stands for loss of every supply, the time is held still. It stays still until a transaction commits at least one byte.

Top module: `cal_clock`

## Requirements
- R1: Byte addresses: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 weekday. All fields are BCD. Year 00..99 stands for 2000..2099, and weekday counts 00..06. After reset the fields read 00, 00, 80, 01, 01, 00, 00.
- R2: A tick steps seconds. Seconds 59 wrap to 00 and carry into minutes. Minutes 59 wrap to 00 and carry into hours. In 24-hour form, hour 23 wraps to 00 and carries into date and weekday. Weekday 06 wraps to 00.
- R3: April, June, September and November end after 30. February ends after 28, or after 29 in a leap year. All other months end after 31. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R4: A year is a leap year when its value 00..99 is divisible by 4.
- R5: In the hour byte, bit 7 = 1 selects 24-hour form, with bits 5:0 holding 00..23. Bit 7 = 0 selects 12-hour form: bit 5 is the PM flag and bits 4:0 hold 01..12. In 12-hour form the hours run 12, 01 .. 11. The PM flag flips when 11 turns into 12, and the date advances on the step from 11 PM to 12 AM.
- R6: `ack_rd` copies the whole time into a snapshot. `rd_data` shows the snapshot byte at `rd_addr` one cycle after the address is presented. The snapshot does not change with later ticks until the next `ack_rd`.
- R7: `ack_wr` loads the current time into the staging buffer and clears the written marks. A `wr_en` byte replaces its field in the buffer and marks that field. On `stop_ok`, only the marked fields are copied into the live counters, and every unmarked field keeps its running value.
- R8: `abort` discards the buffer and leaves the time unchanged. If `abort` and `stop_ok` arrive in the same cycle, the abort wins.
- R9: A committed byte is readable straight after the commit, and the next tick advances from it. A tick in the same cycle as a commit is absorbed.
- R10: After reset the clock ignores ticks. It starts only when a commit carries at least one written byte. A stop with nothing written does not start it.
- R11: Writes to address 7 have no effect, and reads from address 7 return 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, standing for total power loss |
| tick | input | 1 | One-cycle pulse per second |
| ack_rd | input | 1 | Acknowledge edge before read data: take snapshot |
| ack_wr | input | 1 | Acknowledge edge before write data: load staging buffer |
| stop_ok | input | 1 | Valid stop: commit written bytes |
| abort | input | 1 | Invalid or aborted transaction: discard buffer |
| wr_en | input | 1 | Write one byte into the staging buffer |
| wr_addr | input | ADDR_W | Field address of the write |
| wr_data | input | 8 | BCD byte written |
| rd_addr | input | ADDR_W | Field address of the read |
| rd_data | output | 8 | Snapshot byte, registered |

## Verification
The bench loads 23:59:59 on the last day of every month of all hundred years and steps once. A design with a wrong month length, a wrong February rule or a wrong year-carry would land on a wrong date or month. The bench also runs 3700 consecutive seconds and a full 24-step walk of the 12-hour form. An off-by-one in BCD digit carries, or a misplaced PM toggle or date advance, would show up there.

The bench then aims at the transaction rules:
- A tick between `ack_wr` and `stop_ok` catches a commit that writes stale unwritten fields back.
- A running snapshot shows whether reads come from the snapshot or from the live counters.
- Abort and stop arriving together checks that the abort wins.
- An empty stop after reset must leave the clock halted.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NF     = 7;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HR   = 2;
  localparam int F_DATE = 3;
  localparam int F_MON  = 4;
  localparam int F_YR   = 5;
  localparam int F_DOW  = 6;

  typedef logic [NF-1:0][7:0] caltime_t;

  localparam caltime_t CAL_RESET = {8'h00, 8'h00, 8'h01, 8'h01, 8'h80, 8'h00, 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] x);
    if (x[3:0] == 4'h9) return {x[7:4] + 4'h1, 4'h0};
    return x + 8'h01;
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [7:0] b;
    b = ({4'h0, yr[7:4]} * 8'd10) + {4'h0, yr[3:0]};
    return b[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_advance.sv
module cal_advance
  import cal_pkg::*;
(
  input  caltime_t cur,
  output caltime_t nxt
);
  logic       c_min, c_hr, c_day, c_mon, c_yr, leap;
  logic [7:0] h, hnext, h12i, h24i, mlen;

  always_comb begin
    nxt   = cur;
    h     = cur[F_HR];
    hnext = h;
    h12i  = bcd_inc({3'b000, h[4:0]});
    h24i  = bcd_inc({2'b00, h[5:0]});
    c_day = 1'b0;

    c_min = (cur[F_SEC] == 8'h59);
    nxt[F_SEC] = c_min ? 8'h00 : bcd_inc(cur[F_SEC]);
    c_hr  = c_min && (cur[F_MIN] == 8'h59);
    if (c_min) nxt[F_MIN] = (cur[F_MIN] == 8'h59) ? 8'h00 : bcd_inc(cur[F_MIN]);

    if (h[7]) begin
      if (h[5:0] == 6'h23) begin
        hnext = 8'h80;
        c_day = 1'b1;
      end else begin
        hnext = 8'h80 | h24i;
      end
    end else begin
      if (h[4:0] == 5'h11) begin
        hnext = {2'b00, ~h[5], 5'h12};
        c_day = h[5];
      end else if (h[4:0] == 5'h12) begin
        hnext = {2'b00, h[5], 5'h01};
      end else begin
        hnext = {2'b00, h[5], h12i[4:0]};
      end
    end
    c_day = c_day && c_hr;
    if (c_hr) nxt[F_HR] = hnext;

    leap  = is_leap(cur[F_YR]);
    mlen  = month_len(cur[F_MON], leap);
    c_mon = c_day && (cur[F_DATE] == mlen);
    if (c_day) begin
      nxt[F_DATE] = (cur[F_DATE] == mlen) ? 8'h01 : bcd_inc(cur[F_DATE]);
      nxt[F_DOW]  = (cur[F_DOW] == 8'h06) ? 8'h00 : cur[F_DOW] + 8'h01;
    end
    c_yr = c_mon && (cur[F_MON] == 8'h12);
    if (c_mon) nxt[F_MON] = (cur[F_MON] == 8'h12) ? 8'h01 : bcd_inc(cur[F_MON]);
    if (c_yr)  nxt[F_YR]  = (cur[F_YR] == 8'h99) ? 8'h00 : bcd_inc(cur[F_YR]);
  end
endmodule

// File: rtl/cal_snap.sv
module cal_snap
  import cal_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  caltime_t          live,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  caltime_t snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap    <= CAL_RESET;
      rd_data <= 8'h00;
    end else begin
      if (cap) snap <= live;
      rd_data <= (int'(rd_addr) < NF) ? snap[rd_addr] : 8'h00;
    end
  end

  // R6: snapshot frozen between captures
  a_r6_snap_hold: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(snap));
endmodule

// File: rtl/cal_stage.sv
module cal_stage
  import cal_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  caltime_t          live,
  output caltime_t          stage,
  output logic [NF-1:0]     dirty
);
  for (genvar i = 0; i < NF; i++) begin : g_field
    logic hit;
    assign hit = wr_en && (int'(wr_addr) == i);
    always_ff @(posedge clk) begin
      if (rst) begin
        stage[i] <= 8'h00;
        dirty[i] <= 1'b0;
      end else begin
        if (hit)       stage[i] <= wr_data;
        else if (load) stage[i] <= live[i];
        if (clear)     dirty[i] <= 1'b0;
        else if (hit)  dirty[i] <= 1'b1;
        else if (load) dirty[i] <= 1'b0;
      end
    end
  end

  // R7: acknowledge before write data starts with no marked fields
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (load && !wr_en) |=> (dirty == '0));
  // R11: a write to an unused address marks nothing
  a_r11_bad_addr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_addr) >= NF && !load && !clear) |=> $stable(dirty));
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ack_rd,
  input  logic              ack_wr,
  input  logic              stop_ok,
  input  logic              abort,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  caltime_t      live, adv, stage;
  logic [NF-1:0] dirty;
  logic          run, commit;

  assign commit = stop_ok && !abort;

  cal_advance u_adv (.cur(live), .nxt(adv));

  cal_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk(clk), .rst(rst), .load(ack_wr), .clear(stop_ok || abort),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .live(live), .stage(stage), .dirty(dirty)
  );

  cal_snap #(.ADDR_W(ADDR_W)) u_snap (
    .clk(clk), .rst(rst), .cap(ack_rd), .live(live),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= CAL_RESET;
      run  <= 1'b0;
    end else if (commit) begin
      for (int i = 0; i < NF; i++)
        if (dirty[i]) live[i] <= stage[i];
      run <= run || (|dirty);
    end else if (run && tick) begin
      live <= adv;
    end
  end

  // R10: halted clock does not move without a commit
  a_r10_halt: assert property (@(posedge clk) disable iff (rst)
    (!run && !commit) |=> $stable(live));
  // R7: unwritten seconds keep their running value across a commit
  a_r7_partial: assert property (@(posedge clk) disable iff (rst)
    (commit && !dirty[F_SEC]) |=> (live[F_SEC] == $past(live[F_SEC])));
  // R8: abort leaves the time alone
  a_r8_abort: assert property (@(posedge clk) disable iff (rst)
    (abort && !(run && tick)) |=> $stable(live));
  // R2: seconds wrap
  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !commit && live[F_SEC] == 8'h59) |=> (live[F_SEC] == 8'h00));
endmodule

// File: tb/sim_cal_clock.sv
module sim_cal_clock;
  logic       clk = 1'b0, rst = 1'b1;
  logic       tick = 0, ack_rd = 0, ack_wr = 0, stop_ok = 0, abort = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] got;

  always #2 clk = ~clk;

  cal_clock u0 (.clk(clk), .rst(rst), .tick(tick), .ack_rd(ack_rd), .ack_wr(ack_wr),
    .stop_ok(stop_ok), .abort(abort), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] bcd(input int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hr12(input int h24);
    int h;
    h = (h24 % 12 == 0) ? 12 : h24 % 12;
    return bcd(h) | ((h24 >= 12) ? 8'h20 : 8'h00);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic do_tick(); pulse(tick); endtask
  task automatic snap(); pulse(ack_rd); endtask
  task automatic open_wr(); pulse(ack_wr); endtask
  task automatic stop(); pulse(stop_ok); endtask

  task automatic wb(input int a, input logic [7:0] d);
    @(negedge clk) begin wr_en = 1; wr_addr = 3'(a); wr_data = d; end
    @(negedge clk) wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk) rd_addr = 3'(a);
    @(negedge clk) v = rd_data;
  endtask

  task automatic set_all(input logic [7:0] s, mi, h, d, mo, y, w);
    open_wr();
    wb(0, s); wb(1, mi); wb(2, h); wb(3, d); wb(4, mo); wb(5, y); wb(6, w);
    stop();
  endtask

  initial begin
    logic [7:0] rst_exp [7];
    rst_exp = '{8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00};
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset values; R10 halted and empty stop does not start
    repeat (3) do_tick();
    open_wr(); stop();
    repeat (2) do_tick();
    snap();
    for (int a = 0; a < 7; a++) begin rd(a, got); chk("R1/R10 reset state", got, rst_exp[a]); end
    rd(7, got); chk("R11 read addr 7", got, 8'h00);

    // R10 first write starts clock; R7 single field write
    open_wr(); wb(0, 8'h10); stop();
    snap(); rd(0, got); chk("R9 committed value", got, 8'h10);
    rd(1, got); chk("R7 min untouched", got, 8'h00);
    repeat (3) do_tick();
    snap(); rd(0, got); chk("R10 running after write", got, 8'h13);

    // R2 long seconds/minutes/hours sweep in 24h
    set_all(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00);
    for (int i = 1; i <= 3700; i++) begin
      do_tick(); snap();
      rd(0, got); chk("R2 seconds", got, bcd(i % 60));
      rd(1, got); chk("R2 minutes", got, bcd((i / 60) % 60));
      rd(2, got); chk("R2 hours 24h", got, 8'h80 | bcd(i / 3600));
    end

    // R2 day carry and weekday wrap
    set_all(8'h59, 8'h59, 8'h80 | 8'h23, 8'h10, 8'h05, 8'h07, 8'h06);
    do_tick(); snap();
    rd(2, got); chk("R2 hour wrap", got, 8'h80);
    rd(3, got); chk("R2 date carry", got, 8'h11);
    rd(6, got); chk("R2 weekday wrap", got, 8'h00);

    // R3/R4 every month end of every year
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        set_all(8'h59, 8'h59, 8'hA3, bcd(mdays(m, y)), bcd(m), bcd(y), 8'h02);
        do_tick(); snap();
        rd(3, got); chk("R3/R4 date after month end", got, 8'h01);
        rd(4, got); chk("R3 month after month end", got, bcd(m == 12 ? 1 : m + 1));
        rd(5, got); chk("R3 year", got, bcd(m == 12 ? (y + 1) % 100 : y));
      end
    end
    // R4 day before February end does not wrap
    set_all(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h24, 8'h02);
    do_tick(); snap(); rd(3, got); chk("R4 leap Feb 29", got, 8'h29);

    // R5 12-hour walk
    set_all(8'h00, 8'h00, hr12(0), 8'h05, 8'h03, 8'h24, 8'h01);
    for (int h = 0; h < 24; h++) begin
      open_wr(); wb(0, 8'h59); wb(1, 8'h59); stop();
      do_tick(); snap();
      rd(2, got); chk("R5 12h hour", got, hr12((h + 1) % 24));
      rd(3, got); chk("R5 12h date", got, (h == 23) ? 8'h06 : 8'h05);
    end

    // R6 snapshot frozen while live runs
    set_all(8'h20, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00);
    snap(); repeat (4) do_tick();
    rd(0, got); chk("R6 snapshot frozen", got, 8'h20);
    snap(); rd(0, got); chk("R6 new snapshot", got, 8'h24);

    // R7 tick during transaction: unwritten seconds keep running
    open_wr(); do_tick(); do_tick(); wb(1, 8'h33); stop();
    snap(); rd(0, got); chk("R7 running seconds kept", got, 8'h26);
    rd(1, got); chk("R7 written minutes", got, 8'h33);

    // R8 abort, and abort with stop together
    open_wr(); wb(0, 8'h45); pulse(abort);
    snap(); rd(0, got); chk("R8 abort discards", got, 8'h26);
    open_wr(); wb(0, 8'h47);
    @(negedge clk) begin abort = 1; stop_ok = 1; end
    @(negedge clk) begin abort = 0; stop_ok = 0; end
    snap(); rd(0, got); chk("R8 abort beats stop", got, 8'h26);

    // R9 tick in commit cycle absorbed, next tick advances
    open_wr(); wb(0, 8'h30);
    @(negedge clk) begin stop_ok = 1; tick = 1; end
    @(negedge clk) begin stop_ok = 0; tick = 0; end
    snap(); rd(0, got); chk("R9 tick absorbed", got, 8'h30);
    do_tick(); snap(); rd(0, got); chk("R9 next tick", got, 8'h31);

    // R11 write to address 7 ignored
    open_wr(); wb(7, 8'h55); stop();
    snap();
    rd(0, got); chk("R11 sec kept", got, 8'h31);
    rd(1, got); chk("R11 min kept", got, 8'h33);
    rd(7, got); chk("R11 addr 7 reads 00", got, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule